// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the digital core of a byte-addressed memory that answers as a slave on a two-wire serial bus (clock plus open-drain data). A fast system clock oversamples both bus lines. The block finds start and stop conditions and shifts bytes in and out. It only ever pulls the data line low or lets it go. An internal byte array is the storage. After a select byte that names this device, the master can send a two-byte address and then data bytes to write. It can also read: at the current pointer, at an address it gives first (random read), or as a stream that runs on (sequential read). A lock input guards the array against writes. After each completed write, a fixed busy interval models the programming time. During that interval the device does not answer, so the master can poll for the end of it.

The controller is one state machine. `ST_IDLE` waits for a start. `ST_SEL` receives the select byte, then goes to `ST_SEL_ACK` on a match or back to `ST_IDLE` on a miss. `ST_SEL_ACK` goes to `ST_RDAT` for a read, or to `ST_AHI` for a write. The address path is `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDAT`. The write loop is `ST_WDAT` → `ST_WDAT_ACK` → `ST_WDAT`; when the lock is set, `ST_WDAT` goes to `ST_IDLE` instead. The read loop is `ST_RDAT` → `ST_RACK` → `ST_RDAT` when the master acknowledges, and `ST_RACK` → `ST_IDLE` when it does not. A start detected in any state goes to `ST_SEL`. A stop detected in any state goes to `ST_IDLE`.

Top module: `eeprom_slave`

## Requirements
- R1: The device acknowledges a select byte only when its bits 7..4 are 1010 and its bits 3..1 equal `strap_i[2:0]`. Bit 0 is the direction, with 1 meaning read. Any other select byte gets no acknowledge, and the device stays silent until the next start.
- R2: The data line is pulled low in two cases only. The first is the ninth clock after an accepted byte. The second is a 0 bit of a byte being read out. Outside these cases `sda_pull_o` is 0.
- R3: A start (SDA falls while SCL is high) restarts select reception from any state, including straight after an address, which gives a repeated start. A stop (SDA rises while SCL is high) returns the device to idle.
- R4: The address arrives as a high byte and then a low byte. The low AW bits of these 16 bits choose the location, and a byte written there reads back unchanged.
- R5: While `wr_lock_i` is 1, the select and both address bytes are still acknowledged. Every data byte gets no acknowledge and changes no location.
- R6: During a write, the pointer steps by one inside its 64-byte page. It wraps from page offset 63 back to offset 0 and never crosses into the next page.
- R7: A read returns the byte at the pointer and then steps the pointer by one over the whole array. It wraps from the last location to 0.
- R8: When the master does not acknowledge a read byte, the device lets go of the data line and waits idle.
- R9: After a stop that ends a write in which at least one byte was accepted, the select byte gets no acknowledge for BUSY_CYC clock cycles. A write in which every data byte was refused starts no busy interval.
- R10: While `rst_n` is low, the device drives nothing and acknowledges nothing.
- R11: A read started with no address continues from the location after the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| strap_i | input | 3 | Device address straps, compared with select bits 3..1 |
| wr_lock_i | input | 1 | 1 refuses all data bytes of a write |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The embedded properties check on every cycle that the data line is pulled only in an acknowledge slot or a read-data state. They also check that a start always leaves the machine in select reception with the line released, that the page bits stay put when a write steps the pointer, that a read step adds one across the whole array, that a refused acknowledge ends the read, and that nothing is acknowledged while busy. Only the bench scenarios can show what the stored contents hold. That covers page wrap on real locations, wrap at the top of the array, the pointer carried over into a read with no address, the untouched contents after a locked write, and the length of the busy window as seen from the bus. A behavioural model (array, pointer, expected acknowledges) judges these. A per-cycle monitor also compares the pull output against the windows in which the bench lets the slave drive.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } state_t;

    localparam logic [3:0] TYPE_CODE = 4'b1010;

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] scl_sh;
    logic [SW-1:0] sda_sh;
    logic          scl_q;
    logic          sda_q;

    // Idle bus level is high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SW-2:0], scl_i};
            sda_sh <= {sda_sh[SW-2:0], sda_i};
            scl_q  <= scl_sh[SW-1];
            sda_q  <= sda_sh[SW-1];
        end
    end

    assign scl_lvl   = scl_sh[SW-1];
    assign sda_lvl   = sda_sh[SW-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
    import eep_pkg::*;
#(
    parameter int AW          = 10,
    parameter int PAGE_BITS   = 6,
    parameter int BUSY_CYC    = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    state_t          state, state_nx;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [7:0]      ahi;
    logic [AW-1:0]   addr;
    logic            rw;
    logic            mack;
    logic            written;
    logic [BW-1:0]   busy_cnt;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic byte_done, sel_hit, mem_we, rx_shift;
    logic [7:0] rdata;
    logic [PAGE_BITS-1:0] pg_lo_nx;
    logic [AW-1:0] addr_page_nx;

    bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    byte_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (addr),
        .wdata (shreg),
        .rdata (rdata)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign sel_hit   = (shreg[7:4] == TYPE_CODE) && (shreg[3:1] == strap_i)
                       && (busy_cnt == '0);
    assign rx_shift  = scl_rise && (bitcnt < 4'd8) &&
                       (state inside {ST_SEL, ST_AHI, ST_ALO, ST_WDAT});
    assign mem_we    = (state == ST_WDAT) && byte_done && !wr_lock_i
                       && !start_det && !stop_det;
    assign pg_lo_nx     = addr[PAGE_BITS-1:0] + PAGE_BITS'(1);
    assign addr_page_nx = {addr[AW-1:PAGE_BITS], pg_lo_nx};

    // Next-state decision
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_SEL;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_SEL:      if (byte_done) state_nx = sel_hit ? ST_SEL_ACK : ST_IDLE;
                ST_SEL_ACK:  if (scl_fall)  state_nx = rw ? ST_RDAT : ST_AHI;
                ST_AHI:      if (byte_done) state_nx = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall)  state_nx = ST_ALO;
                ST_ALO:      if (byte_done) state_nx = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall)  state_nx = ST_WDAT;
                ST_WDAT:     if (byte_done) state_nx = wr_lock_i ? ST_IDLE : ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall)  state_nx = ST_WDAT;
                ST_RDAT:     if (byte_done) state_nx = ST_RACK;
                ST_RACK:     if (scl_fall)  state_nx = mack ? ST_RDAT : ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            shreg      <= '0;
            ahi        <= '0;
            addr       <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            written    <= 1'b0;
            busy_cnt   <= '0;
            sda_pull_o <= 1'b0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - BW'(1);
            if (stop_det) begin
                sda_pull_o <= 1'b0;
                written    <= 1'b0;
                if (written) busy_cnt <= BW'(BUSY_CYC);
            end else if (start_det) begin
                sda_pull_o <= 1'b0;
                bitcnt     <= '0;
            end else begin
                if (rx_shift) begin
                    shreg  <= {shreg[6:0], sda_lvl};
                    bitcnt <= bitcnt + 4'd1;
                end
                unique case (state)
                    ST_SEL: if (byte_done && sel_hit) begin
                        sda_pull_o <= 1'b1;
                        rw         <= shreg[0];
                    end
                    ST_AHI: if (byte_done) begin
                        sda_pull_o <= 1'b1;
                        ahi        <= shreg;
                    end
                    ST_ALO: if (byte_done) begin
                        sda_pull_o <= 1'b1;
                        addr       <= AW'({ahi, shreg});
                    end
                    ST_WDAT: if (byte_done && !wr_lock_i) begin
                        sda_pull_o <= 1'b1;
                        written    <= 1'b1;
                        addr       <= addr_page_nx;
                    end
                    ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: if (scl_fall) begin
                        bitcnt <= '0;
                        if (state == ST_SEL_ACK && rw) begin
                            shreg      <= rdata;
                            sda_pull_o <= ~rdata[7];
                            bitcnt     <= 4'd1;
                            addr       <= addr + AW'(1);
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                    ST_RDAT: if (scl_fall) begin
                        if (bitcnt < 4'd8) begin
                            sda_pull_o <= ~shreg[6];
                            shreg      <= {shreg[6:0], 1'b0};
                            bitcnt     <= bitcnt + 4'd1;
                        end else begin
                            sda_pull_o <= 1'b0;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack <= ~sda_lvl;
                        if (scl_fall && mack) begin
                            shreg      <= rdata;
                            sda_pull_o <= ~rdata[7];
                            bitcnt     <= 4'd1;
                            addr       <= addr + AW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: the line is pulled only in an acknowledge slot or while sending data
    a_r2_pull_window: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> (state inside {ST_SEL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK, ST_RDAT}));

    // R3: a start always lands in select reception with the line released
    a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_SEL && bitcnt == 4'd0 && !sda_pull_o));

    // R5: a data byte finished under lock is not acknowledged
    a_r5_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDAT && byte_done && wr_lock_i) |=> !sda_pull_o);

    // R6: a write step keeps the page and advances the offset modulo the page
    a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ($stable(addr[AW-1:PAGE_BITS]) &&
                    addr[PAGE_BITS-1:0] == PAGE_BITS'($past(addr[PAGE_BITS-1:0]) + 1'b1)));

    // R7: each further read byte advances the pointer across the whole array
    a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && mack && !start_det && !stop_det)
        |=> addr == AW'($past(addr) + 1'b1));

    // R8: a refused read acknowledge ends the transfer
    a_r8_nack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && scl_fall && !mack && !start_det && !stop_det)
        |=> (state == ST_IDLE && !sda_pull_o));

    // R9: no select acknowledge while the programming interval runs
    a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |-> (state != ST_SEL_ACK));

endmodule

// File: tb/tb_eeprom_slave.sv
`timescale 1ns/1ps
module tb_eeprom_slave;
    localparam int AW    = 10;
    localparam int BUSY  = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic lock = 1'b0;
    logic pull;
    logic sda_line;
    logic may_drive = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [0:(1<<AW)-1];
    int ref_ptr = 0;

    assign sda_line = sda_m & ~pull;

    always #2 clk = ~clk;

    eeprom_slave #(.AW(AW), .PAGE_BITS(6), .BUSY_CYC(BUSY), .SYNC_STAGES(2)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .strap_i    (STRAP),
        .wr_lock_i  (lock),
        .sda_pull_o (pull)
    );

    // Per-cycle monitor (R2, R10): outside the windows the bench grants, the pull stays off
    always @(posedge clk) begin
        #1;
        if (!may_drive) begin
            n_cmp++;
            if (pull !== 1'b0) begin
                n_bad++;
                $display("FAIL R2/R10 pull outside window actual=%b expected=0 t=%0t", pull, $time);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(5);
        scl = 1'b1;   wt(6);
        sda_m = 1'b0; wt(6);
        scl = 1'b0;   wt(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(5);
        scl = 1'b1;   wt(6);
        sda_m = 1'b1; wt(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(5);
            scl = 1'b1;   wt(8);
            scl = 1'b0;
            if (i == 0) may_drive = 1'b1;
            wt(3);
        end
        sda_m = 1'b1; wt(5);
        scl = 1'b1;   wt(4);
        acked = (sda_line == 1'b0);
        wt(4);
        scl = 1'b0;   wt(3);
        may_drive = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        may_drive = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(5);
            scl = 1'b1; wt(4);
            b[i] = sda_line;
            wt(4);
            scl = 1'b0; wt(3);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wt(5);
        scl = 1'b1; wt(8);
        scl = 1'b0; wt(3);
        sda_m = 1'b1;
        may_drive = 1'b0;
    endtask

    task automatic send_addr(input int a, input string req);
        logic ak;
        bus_start();
        send_byte(SEL_W, ak);   check({req, " select ack"}, ak, 1);
        send_byte(8'(a >> 8), ak); check({req, " addr hi ack"}, ak, 1);
        send_byte(8'(a), ak);   check({req, " addr lo ack"}, ak, 1);
    endtask

    task automatic do_write(input int a, input logic [7:0] q[$], input logic exp_ack, input string req);
        logic ak;
        int p;
        send_addr(a, req);
        p = a;
        foreach (q[k]) begin
            send_byte(q[k], ak);
            check({req, " data ack"}, ak, exp_ack);
            if (!ak) break;
            ref_mem[p] = q[k];
            p = (p & ~63) | ((p + 1) & 63);
        end
        if (exp_ack) ref_ptr = p;
        bus_stop();
    endtask

    task automatic read_n(input int n, input string req);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n - 1);
            check(req, b, ref_mem[ref_ptr]);
            ref_ptr = (ref_ptr + 1) % (1 << AW);
        end
        wt(4);
        check("R8 line released after refused ack", pull, 0);
        bus_stop();
    endtask

    task automatic do_rread(input int a, input int n, input string req);
        logic ak;
        send_addr(a, req);
        ref_ptr = a;
        bus_start();
        send_byte(SEL_R, ak); check({req, " read select ack"}, ak, 1);
        read_n(n, req);
    endtask

    initial begin
        logic ak;
        // R10: bus activity during reset is ignored
        wt(3);
        check("R10 pull low in reset", pull, 0);
        bus_start();
        send_byte(SEL_W, ak);
        check("R10 no ack in reset", ak, 0);
        bus_stop();
        rst_n = 1'b1;
        wt(10);

        // R1: wrong type code and wrong straps are ignored
        bus_start();
        send_byte(8'hBA, ak); check("R1 wrong type code", ak, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA2, ak); check("R1 wrong strap", ak, 0);
        bus_stop();

        // R4: byte write, then R9 busy polling
        do_write(16'h0155, '{8'hA5}, 1'b1, "R4 byte write");
        bus_start();
        send_byte(SEL_W, ak); check("R9 busy poll refused", ak, 0);
        bus_stop();
        wt(BUSY + 100);
        bus_start();
        send_byte(SEL_W, ak); check("R9 ack after busy", ak, 1);
        bus_stop();

        // R4, R7: random read returns written byte; R3 repeated start
        do_rread(16'h0155, 1, "R4 R3 random read");

        // R6: page write wraps inside its page
        do_write(16'h0140, '{8'h5C}, 1'b1, "R6 setup");
        wt(BUSY + 100);
        do_write(16'h013E, '{8'h11, 8'h22, 8'h33, 8'h44}, 1'b1, "R6 page write");
        wt(BUSY + 100);
        do_rread(16'h0100, 2, "R6 wrapped bytes");
        do_rread(16'h013E, 2, "R6 page tail");

        // R11: current-address read continues at 0x140
        bus_start();
        send_byte(SEL_R, ak); check("R11 select ack", ak, 1);
        read_n(1, "R11 current read");

        // R7: sequential read wraps from top to 0
        do_write(16'h03FF, '{8'hE1}, 1'b1, "R7 setup top");
        wt(BUSY + 100);
        do_write(16'h0000, '{8'h0F}, 1'b1, "R7 setup zero");
        wt(BUSY + 100);
        do_rread(16'h03FF, 3, "R7 sequential wrap");

        // R5: locked write refuses data, contents unchanged, no busy (R9)
        lock = 1'b1;
        do_write(16'h0155, '{8'h00, 8'h01}, 1'b0, "R5 locked write");
        lock = 1'b0;
        bus_start();
        send_byte(SEL_W, ak); check("R9 no busy after refused write", ak, 1);
        bus_stop();
        do_rread(16'h0155, 1, "R5 contents kept");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule